// File: doc/BRIEF.md
# DDR2/DDR3 SDRAM Power-Up Initialization Sequencer

This block brings an external DDR2 or DDR3 SDRAM from power-up to normal operation. After a one-cycle `start` pulse it captures the memory type, geometry settings, base address and refresh rate. It then walks through the power-up command list for the selected memory type. Commands go out one at a time on a valid/ready command port, and each one carries a 3-bit mode code and a target address. Timed pauses are counted in clock cycles, derived from microsecond figures and a clock-frequency parameter.

The extended mode registers are selected through bank-address bits. Their bit position depends on the column count, the row count, the data-bus width and the address-decode mode. The sequencer computes that position from the captured settings. Two level outputs qualify particular mode-register commands: one requests a DLL reset and one requests the default output-driver calibration. When the last step has been accepted, `init_done` rises and the captured refresh rate is presented on `rfsh_rate` for the refresh logic to load.

Top module: `ddr_init_seq`

## Requirements
- R1: A `start` pulse taken while idle or done sets `busy` and opens the sequence with a NOP command (code 1) on the next cycle.
- R2: The bank offset is 9 + column field + (row field + 11 when decoding is sequential, i.e. `cfg_interleave`=0 or controller version below 0x140) + (1 for half bus width, 2 for full).
- R3: An extended mode-register command for register n (n = 1, 2, 3) targets `base_addr` + (n << bank offset); every other command targets `base_addr`.
- R4: The DDR2 flow (`mem_ddr3`=0) issues these codes in order: 1 (NOP), 1, 2 (precharge all), 5 (extended mode reg, n=2), 5 (n=3), 5 (n=1), 3 (mode reg), 2, 4 (refresh), 4, 3, 5 (n=1), 5 (n=1), 0 (normal mode), then the dummy write.
- R5: A pause of exactly US × CLK_MHZ cycles, with `cmd_valid` low, follows the first NOP: 200 us for DDR2 and 500 us for DDR3. In the DDR3 flow a further 50 us pause follows the DLL-reset mode-register command.
- R6: A command stays on the port with all fields unchanged until `cmd_ready` is sampled high, and the next step starts on the following cycle.
- R7: In the DDR2 flow, `dll_reset` is high during the first mode-register command, the second precharge and both refreshes. `ocd_default` is high during the first of the two final n=1 extended commands. Both flags are low at all other times and throughout the DDR3 flow.
- R8: The DDR3 flow (`mem_ddr3`=1) issues these codes in order: 1, 1, 5 (n=2), 5 (n=3), 5 (n=1), 3, 6 (ZQ calibration), 0, then the dummy write.
- R9: `init_done` and `rfsh_rate` stay 0 until completion. The second cycle after the dummy write is accepted, `init_done` is 1 and `rfsh_rate` equals the rate that was captured at start.
- R10: A `start` pulse while `busy` is high has no effect on the sequence in progress.
- R11: Configuration, base address and rate inputs are sampled only when `start` is accepted; later changes alter neither the commands nor `rfsh_rate`.
- R12: The dummy write is a command with `cmd_write`=1, code 0 and target `base_addr`, and it follows the normal-mode command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence |
| mem_ddr3 | input | 1 | 1 selects DDR3 flow, 0 DDR2 |
| cfg_col | input | 2 | Column-count field |
| cfg_row | input | 2 | Row-count field |
| cfg_half_bus | input | 1 | 1 = half data-bus width |
| cfg_interleave | input | 1 | 1 = interleaved bank decode |
| base_addr | input | ADDR_W | Memory base address |
| rfsh_rate_in | input | RATE_W | Refresh rate to hand over |
| cmd_ready | input | 1 | Target accepts current command |
| cmd_valid | output | 1 | Command present |
| cmd_code | output | 3 | Mode code |
| cmd_addr | output | ADDR_W | Command target address |
| cmd_write | output | 1 | Command is the dummy write |
| dll_reset | output | 1 | DLL-reset qualifier level |
| ocd_default | output | 1 | Calibration-default qualifier level |
| busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Sequence complete |
| rfsh_rate | output | RATE_W | Refresh rate, valid with init_done |

## Verification
A wrong step index shows up as a wrong code, flag or address on the very next command offered. Because the expected list is fixed per memory type, such an error is caught at its first appearance rather than at the end. A miscounted pause shows up as a shorter or longer run of idle cycles before the following NOP or ZQ command. A bad bank offset appears only on the extended mode-register addresses, so every run compares those against an offset recomputed from the applied settings. Stale captured settings or a start pulse that was not ignored show up as mismatched addresses, restarted NOPs or a wrong `rfsh_rate` at completion.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    CMD_NORMAL  = 3'd0,
    CMD_NOP     = 3'd1,
    CMD_PREALL  = 3'd2,
    CMD_LMR     = 3'd3,
    CMD_REFRESH = 3'd4,
    CMD_EXT_LMR = 3'd5,
    CMD_ZQ      = 3'd6
  } cmd_code_e;

  typedef enum logic [1:0] {
    SK_CMD   = 2'd0,
    SK_WAIT  = 2'd1,
    SK_WRITE = 2'd2,
    SK_END   = 2'd3
  } step_kind_e;

  typedef enum logic [1:0] {
    WT_NONE  = 2'd0,
    WT_PWRUP = 2'd1,
    WT_DLL   = 2'd2
  } wait_sel_e;

  typedef struct packed {
    step_kind_e kind;
    cmd_code_e  code;
    logic [1:0] emr;   // extended register number, 0 = none
    logic       dll;
    logic       ocd;
    wait_sel_e  wsel;
  } step_t;

  function automatic step_t mk_step(step_kind_e k, cmd_code_e c, logic [1:0] e,
                                    logic d, logic o, wait_sel_e w);
    step_t s;
    s.kind = k;
    s.code = c;
    s.emr  = e;
    s.dll  = d;
    s.ocd  = o;
    s.wsel = w;
    return s;
  endfunction

  function automatic step_t cmd_step(cmd_code_e c, logic [1:0] e, logic d, logic o);
    return mk_step(SK_CMD, c, e, d, o, WT_NONE);
  endfunction

  // DDR2 power-up list
  function automatic step_t ddr2_step(logic [IDX_W-1:0] i);
    step_t s;
    case (i)
      5'd0:    s = cmd_step(CMD_NOP, 2'd0, 1'b0, 1'b0);
      5'd1:    s = mk_step(SK_WAIT, CMD_NOP, 2'd0, 1'b0, 1'b0, WT_PWRUP);
      5'd2:    s = cmd_step(CMD_NOP, 2'd0, 1'b0, 1'b0);
      5'd3:    s = cmd_step(CMD_PREALL, 2'd0, 1'b0, 1'b0);
      5'd4:    s = cmd_step(CMD_EXT_LMR, 2'd2, 1'b0, 1'b0);
      5'd5:    s = cmd_step(CMD_EXT_LMR, 2'd3, 1'b0, 1'b0);
      5'd6:    s = cmd_step(CMD_EXT_LMR, 2'd1, 1'b0, 1'b0);
      5'd7:    s = cmd_step(CMD_LMR, 2'd0, 1'b1, 1'b0);
      5'd8:    s = cmd_step(CMD_PREALL, 2'd0, 1'b1, 1'b0);
      5'd9:    s = cmd_step(CMD_REFRESH, 2'd0, 1'b1, 1'b0);
      5'd10:   s = cmd_step(CMD_REFRESH, 2'd0, 1'b1, 1'b0);
      5'd11:   s = cmd_step(CMD_LMR, 2'd0, 1'b0, 1'b0);
      5'd12:   s = cmd_step(CMD_EXT_LMR, 2'd1, 1'b0, 1'b1);
      5'd13:   s = cmd_step(CMD_EXT_LMR, 2'd1, 1'b0, 1'b0);
      5'd14:   s = cmd_step(CMD_NORMAL, 2'd0, 1'b0, 1'b0);
      5'd15:   s = mk_step(SK_WRITE, CMD_NORMAL, 2'd0, 1'b0, 1'b0, WT_NONE);
      default: s = mk_step(SK_END, CMD_NORMAL, 2'd0, 1'b0, 1'b0, WT_NONE);
    endcase
    return s;
  endfunction

  // DDR3 power-up list
  function automatic step_t ddr3_step(logic [IDX_W-1:0] i);
    step_t s;
    case (i)
      5'd0:    s = cmd_step(CMD_NOP, 2'd0, 1'b0, 1'b0);
      5'd1:    s = mk_step(SK_WAIT, CMD_NOP, 2'd0, 1'b0, 1'b0, WT_PWRUP);
      5'd2:    s = cmd_step(CMD_NOP, 2'd0, 1'b0, 1'b0);
      5'd3:    s = cmd_step(CMD_EXT_LMR, 2'd2, 1'b0, 1'b0);
      5'd4:    s = cmd_step(CMD_EXT_LMR, 2'd3, 1'b0, 1'b0);
      5'd5:    s = cmd_step(CMD_EXT_LMR, 2'd1, 1'b0, 1'b0);
      5'd6:    s = cmd_step(CMD_LMR, 2'd0, 1'b0, 1'b0);
      5'd7:    s = mk_step(SK_WAIT, CMD_NOP, 2'd0, 1'b0, 1'b0, WT_DLL);
      5'd8:    s = cmd_step(CMD_ZQ, 2'd0, 1'b0, 1'b0);
      5'd9:    s = cmd_step(CMD_NORMAL, 2'd0, 1'b0, 1'b0);
      5'd10:   s = mk_step(SK_WRITE, CMD_NORMAL, 2'd0, 1'b0, 1'b0, WT_NONE);
      default: s = mk_step(SK_END, CMD_NORMAL, 2'd0, 1'b0, 1'b0, WT_NONE);
    endcase
    return s;
  endfunction

  // Bank-select bit position for the extended mode registers
  function automatic logic [4:0] bank_offset(logic [1:0] col, logic [1:0] row,
                                             logic half_bus, logic interleave,
                                             logic [15:0] version);
    logic [4:0] o;
    o = 5'd9 + {3'b000, col};
    if (!(interleave && (version >= 16'h0140)))
      o = o + {3'b000, row} + 5'd11;
    o = o + (half_bus ? 5'd1 : 5'd2);
    return o;
  endfunction

endpackage

// File: rtl/ddr_init_bank_offset.sv
module ddr_init_bank_offset
  import ddr_init_pkg::*;
#(
  parameter logic [15:0] CTRL_VERSION = 16'h0140
) (
  input  logic [1:0] col,
  input  logic [1:0] row,
  input  logic       half_bus,
  input  logic       interleave,
  output logic [4:0] offset
);
  always_comb offset = bank_offset(col, row, half_bus, interleave, CTRL_VERSION);
endmodule

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
(
  input  logic             ddr3,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  step_t s2, s3;
  always_comb begin
    s2   = ddr2_step(idx);
    s3   = ddr3_step(idx);
    step = ddr3 ? s3 : s2;
  end
endmodule

// File: rtl/ddr_init_delay.sv
module ddr_init_delay
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PWRUP2_US = 200,
  parameter int PWRUP3_US = 500,
  parameter int DLL_US    = 50,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ddr3,
  input  wait_sel_e        wsel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LEN_P2  = CNT_W'(PWRUP2_US * CLK_MHZ);
  localparam logic [CNT_W-1:0] LEN_P3  = CNT_W'(PWRUP3_US * CLK_MHZ);
  localparam logic [CNT_W-1:0] LEN_DLL = CNT_W'(DLL_US * CLK_MHZ);

  always_comb begin
    case (wsel)
      WT_PWRUP: len = ddr3 ? LEN_P3 : LEN_P2;
      WT_DLL:   len = LEN_DLL;
      default:  len = CNT_W'(1);
    endcase
  end

  assign expire = active && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!active || expire) cnt <= '0;
    else                        cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          RATE_W       = 12,
  parameter int          CLK_MHZ      = 100,
  parameter int          PWRUP2_US    = 200,
  parameter int          PWRUP3_US    = 500,
  parameter int          DLL_US       = 50,
  parameter logic [15:0] CTRL_VERSION = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_ddr3,
  input  logic [1:0]        cfg_col,
  input  logic [1:0]        cfg_row,
  input  logic              cfg_half_bus,
  input  logic              cfg_interleave,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [RATE_W-1:0] rfsh_rate_in,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_write,
  output logic              dll_reset,
  output logic              ocd_default,
  output logic              busy,
  output logic              init_done,
  output logic [RATE_W-1:0] rfsh_rate
);
  localparam int MAX_US  = (PWRUP3_US > PWRUP2_US) ?
                           ((PWRUP3_US > DLL_US) ? PWRUP3_US : DLL_US) :
                           ((PWRUP2_US > DLL_US) ? PWRUP2_US : DLL_US);
  localparam int MAX_CYC = MAX_US * CLK_MHZ;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} run_state_e;

  run_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              ddr3_q, half_q, il_q;
  logic [1:0]        col_q, row_q;
  logic [ADDR_W-1:0] base_q;
  logic [RATE_W-1:0] rate_q;

  step_t             step;
  logic [4:0]        bank_off;
  logic              running;
  logic              step_adv;
  logic              wait_active;
  logic              wait_expire;
  logic [CNT_W-1:0]  wait_cnt;
  logic [CNT_W-1:0]  wait_len;
  logic              accept_start;

  ddr_init_step_rom u_rom (
    .ddr3 (ddr3_q),
    .idx  (idx),
    .step (step)
  );

  ddr_init_bank_offset #(.CTRL_VERSION(CTRL_VERSION)) u_boff (
    .col        (col_q),
    .row        (row_q),
    .half_bus   (half_q),
    .interleave (il_q),
    .offset     (bank_off)
  );

  ddr_init_delay #(
    .CLK_MHZ   (CLK_MHZ),
    .PWRUP2_US (PWRUP2_US),
    .PWRUP3_US (PWRUP3_US),
    .DLL_US    (DLL_US),
    .CNT_W     (CNT_W)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (wait_active),
    .ddr3   (ddr3_q),
    .wsel   (step.wsel),
    .cnt    (wait_cnt),
    .len    (wait_len),
    .expire (wait_expire)
  );

  function automatic logic [ADDR_W-1:0] target_addr(logic [ADDR_W-1:0] base,
                                                    logic [1:0] n, logic [4:0] off);
    return base + (ADDR_W'(n) << off);
  endfunction

  assign running      = (state == S_RUN);
  assign accept_start = start && !running;
  assign wait_active  = running && (step.kind == SK_WAIT);
  assign cmd_valid    = running && ((step.kind == SK_CMD) || (step.kind == SK_WRITE));
  assign cmd_write    = running && (step.kind == SK_WRITE);
  assign cmd_code     = cmd_valid ? step.code : CMD_NOP;
  assign cmd_addr     = cmd_valid ? target_addr(base_q, step.emr, bank_off) : '0;
  assign dll_reset    = running && step.dll;
  assign ocd_default  = running && step.ocd;
  assign busy         = running;
  assign step_adv     = (cmd_valid && cmd_ready) || wait_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      ddr3_q    <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      half_q    <= 1'b0;
      il_q      <= 1'b0;
      base_q    <= '0;
      rate_q    <= '0;
      init_done <= 1'b0;
      rfsh_rate <= '0;
    end else begin
      if (accept_start) begin
        state     <= S_RUN;
        idx       <= '0;
        ddr3_q    <= mem_ddr3;
        col_q     <= cfg_col;
        row_q     <= cfg_row;
        half_q    <= cfg_half_bus;
        il_q      <= cfg_interleave;
        base_q    <= base_addr;
        rate_q    <= rfsh_rate_in;
        init_done <= 1'b0;
        rfsh_rate <= '0;
      end else if (running) begin
        if (step.kind == SK_END) begin
          state     <= S_DONE;
          init_done <= 1'b1;
          rfsh_rate <= rate_q;
        end else if (step_adv) begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RATE_W = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_write,
  input logic              dll_reset,
  input logic              ocd_default,
  input logic              busy,
  input logic              init_done,
  input logic [RATE_W-1:0] rfsh_rate,
  input logic              step_adv,
  input logic [IDX_W-1:0]  step_idx,
  input logic              wait_active,
  input logic [CNT_W-1:0]  wait_cnt,
  input logic [CNT_W-1:0]  wait_len,
  input logic [4:0]        bank_off
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr)
      && $stable(cmd_write) && $stable(dll_reset) && $stable(ocd_default));

  // R9
  no_rate_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> rfsh_rate == '0);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid && !busy);

  // R1
  opens_with_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && (cmd_code == CMD_NOP) && !cmd_write);

  // R7
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dll_reset && ocd_default));

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> wait_cnt < wait_len && !cmd_valid);

  // R2
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bank_off >= 5'd10) && (bank_off <= 5'd28));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !step_adv |=> busy && $stable(step_idx));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ADDR_W (ADDR_W),
  .RATE_W (RATE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cmd_ready   (cmd_ready),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_addr    (cmd_addr),
  .cmd_write   (cmd_write),
  .dll_reset   (dll_reset),
  .ocd_default (ocd_default),
  .busy        (busy),
  .init_done   (init_done),
  .rfsh_rate   (rfsh_rate),
  .step_adv    (step_adv),
  .step_idx    (idx),
  .wait_active (wait_active),
  .wait_cnt    (wait_cnt),
  .wait_len    (wait_len),
  .bank_off    (bank_off)
);

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;
  localparam int AW  = 32;
  localparam int RW  = 12;
  localparam int MHZ = 2;
  localparam int P2  = 200;
  localparam int P3  = 500;
  localparam int DL  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_ddr3 = 1'b0;
  logic [1:0] cfg_col = '0, cfg_row = '0;
  logic cfg_half_bus = 1'b0, cfg_interleave = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [RW-1:0] rfsh_rate_in = '0;
  logic cmd_ready = 1'b0;
  logic cmd_valid, cmd_write, dll_reset, ocd_default, busy, init_done;
  logic [2:0] cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [RW-1:0] rfsh_rate;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(AW), .RATE_W(RW), .CLK_MHZ(MHZ),
    .PWRUP2_US(P2), .PWRUP3_US(P3), .DLL_US(DL), .CTRL_VERSION(16'h0140)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ddr3(mem_ddr3),
    .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_half_bus(cfg_half_bus),
    .cfg_interleave(cfg_interleave), .base_addr(base_addr),
    .rfsh_rate_in(rfsh_rate_in), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_write(cmd_write),
    .dll_reset(dll_reset), .ocd_default(ocd_default), .busy(busy),
    .init_done(init_done), .rfsh_rate(rfsh_rate)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected command tables
  function automatic int e_code(bit d3, int i);
    int t2[15] = '{1, 1, 2, 5, 5, 5, 3, 2, 4, 4, 3, 5, 5, 0, 0};
    int t3[9]  = '{1, 1, 5, 5, 5, 3, 6, 0, 0};
    return d3 ? t3[i] : t2[i];
  endfunction

  function automatic int e_reg(bit d3, int i);
    int t2[15] = '{0, 0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    int t3[9]  = '{0, 0, 2, 3, 1, 0, 0, 0, 0};
    return d3 ? t3[i] : t2[i];
  endfunction

  function automatic int e_flags(bit d3, int i);  // {dll, ocd}
    if (d3) return 0;
    if (i >= 6 && i <= 9) return 2;
    if (i == 11) return 1;
    return 0;
  endfunction

  function automatic int e_gap(bit d3, int i);
    if (i == 1) return (d3 ? P3 : P2) * MHZ;
    if (d3 && i == 6) return DL * MHZ;
    return 0;
  endfunction

  function automatic int e_off(int col, int row, bit half, bit il);
    int seq_part;
    seq_part = il ? 0 : (row + 11);
    return (half ? 1 : 2) + seq_part + col + 9;
  endfunction

  task automatic run_seq(bit d3, int col, int row, bit half, bit il,
                         logic [AW-1:0] base, logic [RW-1:0] rate,
                         int maxd, bit poke);
    int ncmd, off;
    ncmd = d3 ? 9 : 15;
    off  = e_off(col, row, half, il);
    @(negedge clk);
    mem_ddr3 = d3; cfg_col = 2'(col); cfg_row = 2'(row);
    cfg_half_bus = half; cfg_interleave = il;
    base_addr = base; rfsh_rate_in = rate;
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    // R11: scramble inputs after capture
    mem_ddr3 = ~d3; cfg_col = 2'($urandom); cfg_row = 2'($urandom);
    cfg_half_bus = ~half; cfg_interleave = ~il;
    base_addr = $urandom; rfsh_rate_in = RW'($urandom);
    for (int i = 0; i < ncmd; i++) begin
      int gap, d, eg;
      logic [AW-1:0] ea;
      logic [2:0] c0; logic [AW-1:0] a0; logic [1:0] f0; logic w0;
      bit stable;
      gap = 0;
      @(negedge clk);
      while (!cmd_valid && gap < 5000) begin gap++; @(negedge clk); end
      eg = e_gap(d3, i);
      if (eg > 0) chk(gap == eg, "R5 pause length", gap, eg);
      else chk(gap == 0, "R6 next step follows at once", gap, 0);
      if (i == 0) chk(busy == 1'b1, "R1 busy after start", busy, 1);
      chk(int'(cmd_code) == e_code(d3, i), d3 ? "R8 code order" : "R4 code order",
          cmd_code, e_code(d3, i));
      ea = base + (AW'(e_reg(d3, i)) << off);
      chk(cmd_addr == ea, "R2 R3 target address", cmd_addr, ea);
      chk(int'({dll_reset, ocd_default}) == e_flags(d3, i), "R7 flags",
          {dll_reset, ocd_default}, e_flags(d3, i));
      chk(cmd_write == (i == ncmd - 1), "R12 dummy write", cmd_write, i == ncmd - 1);
      c0 = cmd_code; a0 = cmd_addr; f0 = {dll_reset, ocd_default}; w0 = cmd_write;
      stable = 1'b1;
      d = int'($urandom_range(maxd, 0));
      for (int k = 0; k < d; k++) begin
        start = poke;  // R10: start while busy
        @(negedge clk);
        if (!cmd_valid || cmd_code != c0 || cmd_addr != a0 ||
            {dll_reset, ocd_default} != f0 || cmd_write != w0) stable = 1'b0;
      end
      start = 1'b0;
      if (d > 0) chk(stable, "R6 hold while not ready", stable, 1);
      cmd_ready = 1'b1;
      @(posedge clk); #1 cmd_ready = 1'b0;
    end
    @(negedge clk);
    chk(!init_done && !cmd_valid && rfsh_rate == '0, "R9 not yet done",
        {init_done, cmd_valid, rfsh_rate}, 0);
    @(negedge clk);
    chk(init_done == 1'b1, "R9 done", init_done, 1);
    chk(rfsh_rate == rate, "R9 R11 rate", rfsh_rate, rate);
    rfsh_rate_in = ~rate;
    repeat (3) @(negedge clk);
    chk(rfsh_rate == rate && init_done, "R11 rate held", rfsh_rate, rate);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !busy && !init_done && rfsh_rate == '0, "R9 reset state",
        {cmd_valid, busy, init_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 idle until start", busy, 0);
    // directed corners: largest offset, smallest offset, interleave
    run_seq(1'b0, 3, 3, 1'b0, 1'b0, 32'h2000_0000, 12'h3FF, 0, 1'b0);
    run_seq(1'b1, 0, 0, 1'b1, 1'b1, 32'h0000_0000, 12'h001, 2, 1'b1);
    run_seq(1'b0, 1, 2, 1'b1, 1'b1, 32'hFFFF_FF00, 12'h81A, 3, 1'b1);
    run_seq(1'b1, 3, 3, 1'b0, 1'b0, 32'h7000_0004, 12'hFFF, 1, 1'b0);
    for (int r = 0; r < 8; r++) begin
      run_seq(1'($urandom), int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
              1'($urandom), 1'($urandom), $urandom, RW'($urandom), 4, 1'(r & 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule